// File: doc/BRIEF.md
# Display Command and RAM Access Interface

This block sits between a byte-wide host link and a graphic display memory. Every byte arrives with a valid strobe and a flag that marks it as command (flag low) or data (flag high). A finite-state machine decodes each command byte. It then collects that command's parameter bytes, which arrive with the flag high. The collected values go into window, scan, status and configuration registers. Analog settings such as bias, boost, contrast and regulator gain are only stored and driven out on configuration ports.

After the write-mode opcode, each data byte goes out on the RAM write port at the current column/page pointer. The pointer then advances inside a rectangular window, in column-first or page-first order, and either dimension can be reversed. After the read-mode opcode, host read requests return one dummy byte and then RAM contents. The pointer advances once for every two requests. A lock bit in the bias command stops all traffic except a further bias command.

FSM states: `ST_IDLE` (no command pending), `ST_COL_LO`/`ST_COL_HI` (column window start/end), `ST_PAGE_LO`/`ST_PAGE_HI` (page window start/end), `ST_SCAN` (scan byte), `ST_BIAS` (bias/lock byte), `ST_CONTRAST`/`ST_GAIN` (two contrast bytes), `ST_POWER` (power byte), `ST_WRITE` (pixel write mode) and `ST_READ` (read-back mode). Transitions:
- Any accepted command byte leaves the current state and goes to the state that opcode selects. That is `ST_IDLE` for single-byte and unknown opcodes.
- A data byte moves `ST_COL_LO`→`ST_COL_HI`, `ST_PAGE_LO`→`ST_PAGE_HI` and `ST_CONTRAST`→`ST_GAIN`.
- A data byte in a last-parameter state (`ST_COL_HI`, `ST_PAGE_HI`, `ST_SCAN`, `ST_BIAS`, `ST_GAIN`, `ST_POWER`) returns the FSM to `ST_IDLE`.
- `ST_WRITE` and `ST_READ` hold until a command byte arrives.

Top module: `disp_cmd_if`

## Requirements
- R1: After reset the display, sleep, inverse and lock outputs are 0. All configuration outputs are 0, both windows are 0..0, the scan is forward column-first, no RAM strobe is active and rd_valid is 0.
- R2: Opcode 0x15 takes two data-flagged bytes: column window start, then end. Each value above COL_MAX (32) is stored as COL_MAX.
- R3: Opcode 0x75 takes two data-flagged bytes: page window start, then end. Each value above PAGE_MAX (129) is stored as PAGE_MAX.
- R4: Opcode 0x5C enters write mode and loads the pointer. In write mode, each valid data-flagged byte raises mem_we in the same cycle, with mem_wdata equal to the byte and the address equal to the pointer.
- R5: In column-first order, the column steps from window start to window end. After the end, it returns to the start and the page steps by one. The page likewise returns to its window start after its window end.
- R6: Opcode 0xBC takes one byte: bit 2 selects page-first order, bit 1 reverses the column and bit 0 reverses the page. A reversed dimension is loaded with its window end, counts down to its window start and then returns to the end. In page-first order the page steps on every access and the column steps when the page returns.
- R7: Opcode 0x5D enters read mode and loads the pointer. In read mode, rd_req with in_valid low raises mem_re. One cycle later rd_valid pulses, with rd_data holding the byte.
- R8: The first read request after 0x5D returns 0x00. Every later request returns the RAM byte at the pointer. The pointer advances on the 2nd, 4th, 6th… request.
- R9: Opcodes 0xAF/0xAE set/clear disp_on, 0x95/0x94 set/clear sleep_on, and 0xA7/0xA6 set/clear inverse_on.
- R10: A command-flagged byte ends write, read or parameter collection and is decoded at once. Parameters that already arrived stay in effect. A data-flagged byte with nothing pending changes nothing.
- R11: Opcode 0xFB takes one byte: bits 3:0 go to cfg_bias and bit 4 to locked. While locked, every command except 0xFB and every data byte outside that command's parameter is ignored.
- R12: Opcode 0x81 takes two bytes (cfg_contrast, then cfg_gain). Opcode 0x20 takes one byte (cfg_power). Unlisted opcodes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_dc | input | 1 | 1 = data byte, 0 = command byte |
| in_byte | input | 8 | Incoming byte |
| rd_req | input | 1 | Host read request (honoured when in_valid is low) |
| mem_rdata | input | 8 | RAM read data for the driven address |
| rd_valid | output | 1 | Read byte ready |
| rd_data | output | 8 | Read byte (dummy or RAM data) |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_col | output | $clog2(COL_MAX+1) | RAM column address |
| mem_page | output | $clog2(PAGE_MAX+1) | RAM page address |
| mem_wdata | output | 8 | RAM write data |
| disp_on | output | 1 | Display enabled |
| sleep_on | output | 1 | Sleep state |
| inverse_on | output | 1 | Inverse display |
| locked | output | 1 | Interface lock |
| cfg_bias | output | 4 | Stored bias code |
| cfg_contrast | output | 8 | Stored contrast byte |
| cfg_gain | output | 8 | Stored regulator gain byte |
| cfg_power | output | 8 | Stored power byte |

## Verification
The bench keeps the default COL_MAX of 32 and PAGE_MAX of 129. With these values, window parameters of 40, 50 and 200 exercise saturation, and a window at pages 128..129 reaches the top page and wraps around it. Small windows such as 2..4 by 5..6 expose the column/page carry, reversal and page-first order within a handful of bytes. A behavioural model with its own RAM image checks every strobe, address, read byte and status output on every clock.

// File: rtl/dci_pkg.sv
package dci_pkg;

    localparam logic [7:0] OP_COLWIN   = 8'h15;
    localparam logic [7:0] OP_PAGEWIN  = 8'h75;
    localparam logic [7:0] OP_WRITE    = 8'h5C;
    localparam logic [7:0] OP_READ     = 8'h5D;
    localparam logic [7:0] OP_SCAN     = 8'hBC;
    localparam logic [7:0] OP_BIAS     = 8'hFB;
    localparam logic [7:0] OP_CONTRAST = 8'h81;
    localparam logic [7:0] OP_POWER    = 8'h20;
    localparam logic [7:0] OP_DISP_OFF = 8'hAE;
    localparam logic [7:0] OP_DISP_ON  = 8'hAF;
    localparam logic [7:0] OP_WAKE     = 8'h94;
    localparam logic [7:0] OP_SLEEP    = 8'h95;
    localparam logic [7:0] OP_NORMAL   = 8'hA6;
    localparam logic [7:0] OP_INVERSE  = 8'hA7;

    localparam logic [7:0] DUMMY_BYTE  = 8'h00;

    localparam int SCAN_PAGE_REV   = 0;
    localparam int SCAN_COL_REV    = 1;
    localparam int SCAN_PAGE_FIRST = 2;
    localparam int LOCK_BIT        = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COL_LO,
        ST_COL_HI,
        ST_PAGE_LO,
        ST_PAGE_HI,
        ST_SCAN,
        ST_BIAS,
        ST_CONTRAST,
        ST_GAIN,
        ST_POWER,
        ST_WRITE,
        ST_READ
    } dci_state_e;

    typedef struct packed {
        logic page_first;
        logic col_rev;
        logic page_rev;
    } scan_cfg_t;

endpackage

// File: rtl/dci_step.sv
module dci_step #(
    parameter int W   = 6,
    parameter int MAX = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         rev,
    output logic [W-1:0] nxt,
    output logic         wrap
);

    always_comb begin
        if (!rev) begin
            wrap = (cur == hi) || (int'(cur) >= MAX);
            nxt  = wrap ? lo : cur + W'(1);
        end else begin
            wrap = (cur == lo) || (cur == '0);
            nxt  = wrap ? hi : cur - W'(1);
        end
    end

endmodule

// File: rtl/dci_addr.sv
module dci_addr
    import dci_pkg::*;
#(
    parameter int COL_MAX  = 32,
    parameter int PAGE_MAX = 129,
    localparam int CW = $clog2(COL_MAX + 1),
    localparam int PW = $clog2(PAGE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  scan_cfg_t     scan,
    input  logic [CW-1:0] col_lo,
    input  logic [CW-1:0] col_hi,
    input  logic [PW-1:0] page_lo,
    input  logic [PW-1:0] page_hi,
    output logic [CW-1:0] col,
    output logic [PW-1:0] page
);

    logic [CW-1:0] col_nxt;
    logic [PW-1:0] page_nxt;
    logic          col_wrap;
    logic          page_wrap;

    dci_step #(.W(CW), .MAX(COL_MAX)) u_col_step (
        .cur  (col),
        .lo   (col_lo),
        .hi   (col_hi),
        .rev  (scan.col_rev),
        .nxt  (col_nxt),
        .wrap (col_wrap)
    );

    dci_step #(.W(PW), .MAX(PAGE_MAX)) u_page_step (
        .cur  (page),
        .lo   (page_lo),
        .hi   (page_hi),
        .rev  (scan.page_rev),
        .nxt  (page_nxt),
        .wrap (page_wrap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col  <= '0;
            page <= '0;
        end else if (load) begin
            col  <= scan.col_rev  ? col_hi  : col_lo;
            page <= scan.page_rev ? page_hi : page_lo;
        end else if (step) begin
            if (!scan.page_first) begin
                col <= col_nxt;
                if (col_wrap) begin
                    page <= page_nxt;
                end
            end else begin
                page <= page_nxt;
                if (page_wrap) begin
                    col <= col_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/dci_rdpath.sv
module dci_rdpath
    import dci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       req,
    input  logic [7:0] rdata,
    output logic       adv,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    logic first_q;
    logic odd_q;

    assign adv = req && odd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b1;
            odd_q    <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (start) begin
                first_q <= 1'b1;
                odd_q   <= 1'b0;
            end else if (req) begin
                first_q  <= 1'b0;
                odd_q    <= !odd_q;
                rd_valid <= 1'b1;
                rd_data  <= first_q ? DUMMY_BYTE : rdata;
            end
        end
    end

endmodule

// File: rtl/disp_cmd_if.sv
module disp_cmd_if
    import dci_pkg::*;
#(
    parameter int COL_MAX  = 32,
    parameter int PAGE_MAX = 129,
    localparam int CW = $clog2(COL_MAX + 1),
    localparam int PW = $clog2(PAGE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_dc,
    input  logic [7:0]    in_byte,
    input  logic          rd_req,
    input  logic [7:0]    mem_rdata,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          mem_we,
    output logic          mem_re,
    output logic [CW-1:0] mem_col,
    output logic [PW-1:0] mem_page,
    output logic [7:0]    mem_wdata,
    output logic          disp_on,
    output logic          sleep_on,
    output logic          inverse_on,
    output logic          locked,
    output logic [3:0]    cfg_bias,
    output logic [7:0]    cfg_contrast,
    output logic [7:0]    cfg_gain,
    output logic [7:0]    cfg_power
);

    dci_state_e    state_q, state_d;
    logic          cmd_stb, dat_stb, blocked, enter_mode;
    logic          step_ptr, rd_adv;
    scan_cfg_t     scan_q;
    logic [CW-1:0] col_lo_q, col_hi_q, col_ptr;
    logic [PW-1:0] page_lo_q, page_hi_q, page_ptr;

    function automatic logic [CW-1:0] sat_col(input logic [7:0] v);
        return (int'(v) > COL_MAX) ? CW'(COL_MAX) : CW'(v);
    endfunction

    function automatic logic [PW-1:0] sat_page(input logic [7:0] v);
        return (int'(v) > PAGE_MAX) ? PW'(PAGE_MAX) : PW'(v);
    endfunction

    function automatic dci_state_e decode_op(input logic [7:0] op);
        case (op)
            OP_COLWIN:   return ST_COL_LO;
            OP_PAGEWIN:  return ST_PAGE_LO;
            OP_SCAN:     return ST_SCAN;
            OP_BIAS:     return ST_BIAS;
            OP_CONTRAST: return ST_CONTRAST;
            OP_POWER:    return ST_POWER;
            OP_WRITE:    return ST_WRITE;
            OP_READ:     return ST_READ;
            default:     return ST_IDLE;
        endcase
    endfunction

    assign cmd_stb    = in_valid && !in_dc;
    assign dat_stb    = in_valid && in_dc;
    assign blocked    = locked && (in_byte != OP_BIAS);
    assign enter_mode = cmd_stb && !blocked &&
                        ((in_byte == OP_WRITE) || (in_byte == OP_READ));

    assign mem_we    = dat_stb && (state_q == ST_WRITE);
    assign mem_re    = rd_req && !in_valid && (state_q == ST_READ);
    assign mem_wdata = in_byte;
    assign mem_col   = col_ptr;
    assign mem_page  = page_ptr;
    assign step_ptr  = mem_we || rd_adv;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_stb) begin
            state_d = blocked ? ST_IDLE : decode_op(in_byte);
        end else if (dat_stb) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_COL_LO:   state_d = ST_COL_HI;
                ST_COL_HI:   state_d = ST_IDLE;
                ST_PAGE_LO:  state_d = ST_PAGE_HI;
                ST_PAGE_HI:  state_d = ST_IDLE;
                ST_SCAN:     state_d = ST_IDLE;
                ST_BIAS:     state_d = ST_IDLE;
                ST_CONTRAST: state_d = ST_GAIN;
                ST_GAIN:     state_d = ST_IDLE;
                ST_POWER:    state_d = ST_IDLE;
                ST_WRITE:    state_d = ST_WRITE;
                ST_READ:     state_d = ST_READ;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // registers written by commands and parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_lo_q     <= '0;
            col_hi_q     <= '0;
            page_lo_q    <= '0;
            page_hi_q    <= '0;
            scan_q       <= '0;
            disp_on      <= 1'b0;
            sleep_on     <= 1'b0;
            inverse_on   <= 1'b0;
            locked       <= 1'b0;
            cfg_bias     <= '0;
            cfg_contrast <= '0;
            cfg_gain     <= '0;
            cfg_power    <= '0;
        end else if (cmd_stb && !blocked) begin
            case (in_byte)
                OP_DISP_OFF: disp_on    <= 1'b0;
                OP_DISP_ON:  disp_on    <= 1'b1;
                OP_WAKE:     sleep_on   <= 1'b0;
                OP_SLEEP:    sleep_on   <= 1'b1;
                OP_NORMAL:   inverse_on <= 1'b0;
                OP_INVERSE:  inverse_on <= 1'b1;
                default: ;
            endcase
        end else if (dat_stb) begin
            unique case (state_q)
                ST_COL_LO:   col_lo_q     <= sat_col(in_byte);
                ST_COL_HI:   col_hi_q     <= sat_col(in_byte);
                ST_PAGE_LO:  page_lo_q    <= sat_page(in_byte);
                ST_PAGE_HI:  page_hi_q    <= sat_page(in_byte);
                ST_SCAN: begin
                    scan_q.page_first <= in_byte[SCAN_PAGE_FIRST];
                    scan_q.col_rev    <= in_byte[SCAN_COL_REV];
                    scan_q.page_rev   <= in_byte[SCAN_PAGE_REV];
                end
                ST_BIAS: begin
                    cfg_bias <= in_byte[3:0];
                    locked   <= in_byte[LOCK_BIT];
                end
                ST_CONTRAST: cfg_contrast <= in_byte;
                ST_GAIN:     cfg_gain     <= in_byte;
                ST_POWER:    cfg_power    <= in_byte;
                default: ;
            endcase
        end
    end

    dci_addr #(.COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_mode),
        .step    (step_ptr),
        .scan    (scan_q),
        .col_lo  (col_lo_q),
        .col_hi  (col_hi_q),
        .page_lo (page_lo_q),
        .page_hi (page_hi_q),
        .col     (col_ptr),
        .page    (page_ptr)
    );

    dci_rdpath u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (enter_mode),
        .req      (mem_re),
        .rdata    (mem_rdata),
        .adv      (rd_adv),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/dci_checker.sv
module dci_checker #(
    parameter int COL_MAX  = 32,
    parameter int PAGE_MAX = 129,
    localparam int CW = $clog2(COL_MAX + 1),
    localparam int PW = $clog2(PAGE_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_dc,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          mem_we,
    input logic          mem_re,
    input logic [CW-1:0] mem_col,
    input logic [PW-1:0] mem_page,
    input logic          disp_on,
    input logic          locked
);

    a_r4_write_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && in_dc));

    a_r7_read_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (rd_req && !in_valid));

    a_r7_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_re));

    a_r2_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (int'(mem_col) <= COL_MAX));

    a_r3_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (int'(mem_page) <= PAGE_MAX));

    a_r11_lock_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !(mem_we || mem_re));

    a_r9_quiet_bus_keeps_display: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(disp_on));

endmodule

bind disp_cmd_if dci_checker #(.COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_dc    (in_dc),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_col  (mem_col),
    .mem_page (mem_page),
    .disp_on  (disp_on),
    .locked   (locked)
);

// File: tb/sim_disp_cmd_if.sv
module sim_disp_cmd_if;

    localparam int COL_MAX  = 32;
    localparam int PAGE_MAX = 129;
    localparam int CW       = $clog2(COL_MAX + 1);
    localparam int PW       = $clog2(PAGE_MAX + 1);
    localparam int NCOL     = COL_MAX + 1;
    localparam int NCELL    = NCOL * (PAGE_MAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_dc = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          rd_req = 1'b0;
    logic [7:0]    mem_rdata;
    logic          rd_valid, mem_we, mem_re;
    logic [7:0]    rd_data, mem_wdata;
    logic [CW-1:0] mem_col;
    logic [PW-1:0] mem_page;
    logic          disp_on, sleep_on, inverse_on, locked;
    logic [3:0]    cfg_bias;
    logic [7:0]    cfg_contrast, cfg_gain, cfg_power;

    always #10 clk = ~clk;

    disp_cmd_if #(.COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc),
        .in_byte(in_byte), .rd_req(rd_req), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_we(mem_we),
        .mem_re(mem_re), .mem_col(mem_col), .mem_page(mem_page),
        .mem_wdata(mem_wdata), .disp_on(disp_on), .sleep_on(sleep_on),
        .inverse_on(inverse_on), .locked(locked), .cfg_bias(cfg_bias),
        .cfg_contrast(cfg_contrast), .cfg_gain(cfg_gain), .cfg_power(cfg_power)
    );

    // RAM driven by the design's port
    logic [7:0] ram [0:NCELL-1];
    always_comb mem_rdata = ram[int'(mem_page) * NCOL + int'(mem_col)];
    always @(posedge clk) if (mem_we) ram[int'(mem_page) * NCOL + int'(mem_col)] <= mem_wdata;

    // behavioural reference model
    int mram [NCELL];
    int m_mode, m_op, m_idx;          // mode 0 idle, 1 write, 2 read, 3 parameters
    int m_col, m_page, m_cs, m_ce, m_ps, m_pe;
    bit m_pf, m_cr, m_pr, m_lock, m_on, m_sleep, m_inv, m_first, m_odd, m_rdv;
    int m_bias, m_con, m_gain, m_pow, m_rdd;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    function automatic int npar(input int op);
        return (op == 'h15 || op == 'h75 || op == 'h81) ? 2 : 1;
    endfunction

    task automatic adv_dim(inout int cur, input int lo, input int hi, input int mx,
                           input bit rev, output bit w);
        if (!rev) begin
            w = (cur == hi) || (cur >= mx);
            cur = w ? lo : cur + 1;
        end else begin
            w = (cur == lo) || (cur == 0);
            cur = w ? hi : cur - 1;
        end
    endtask

    task automatic advance();
        bit w1, w2;
        if (!m_pf) begin
            adv_dim(m_col, m_cs, m_ce, COL_MAX, m_cr, w1);
            if (w1) adv_dim(m_page, m_ps, m_pe, PAGE_MAX, m_pr, w2);
        end else begin
            adv_dim(m_page, m_ps, m_pe, PAGE_MAX, m_pr, w1);
            if (w1) adv_dim(m_col, m_cs, m_ce, COL_MAX, m_cr, w2);
        end
    endtask

    task automatic model_step();
        int b;
        b = int'(in_byte);
        m_rdv = 0;
        if (in_valid && !in_dc) begin
            m_mode = 0;
            if (!(m_lock && b != 'hFB)) begin
                case (b)
                    'h15, 'h75, 'hBC, 'hFB, 'h81, 'h20: begin m_mode = 3; m_op = b; m_idx = 0; end
                    'h5C: begin m_mode = 1; m_col = m_cr ? m_ce : m_cs; m_page = m_pr ? m_pe : m_ps; end
                    'h5D: begin m_mode = 2; m_col = m_cr ? m_ce : m_cs; m_page = m_pr ? m_pe : m_ps;
                                m_first = 1; m_odd = 0; end
                    'hAE: m_on = 0;
                    'hAF: m_on = 1;
                    'h94: m_sleep = 0;
                    'h95: m_sleep = 1;
                    'hA6: m_inv = 0;
                    'hA7: m_inv = 1;
                    default: ;
                endcase
            end
        end else if (in_valid && in_dc) begin
            if (m_mode == 1) begin
                mram[m_page * NCOL + m_col] = b;
                advance();
            end else if (m_mode == 3) begin
                case (m_op)
                    'h15: if (m_idx == 0) m_cs = sat(b, COL_MAX); else m_ce = sat(b, COL_MAX);
                    'h75: if (m_idx == 0) m_ps = sat(b, PAGE_MAX); else m_pe = sat(b, PAGE_MAX);
                    'hBC: begin m_pf = b[2]; m_cr = b[1]; m_pr = b[0]; end
                    'hFB: begin m_bias = b & 15; m_lock = b[4]; end
                    'h81: if (m_idx == 0) m_con = b; else m_gain = b;
                    default: m_pow = b;
                endcase
                m_idx++;
                if (m_idx == npar(m_op)) m_mode = 0;
            end
        end else if (rd_req && m_mode == 2) begin
            m_rdv = 1;
            m_rdd = m_first ? 0 : mram[m_page * NCOL + m_col];
            m_first = 0;
            if (m_odd) advance();
            m_odd = !m_odd;
        end
    endtask

    task automatic compare();
        bit exp_we, exp_re;
        exp_we = in_valid && in_dc && m_mode == 1;
        exp_re = rd_req && !in_valid && m_mode == 2;
        check("R4 write strobe", int'(mem_we), int'(exp_we));
        check("R7 read strobe", int'(mem_re), int'(exp_re));
        if (exp_we || exp_re) begin
            check("R2 R5 R6 column address", int'(mem_col), m_col);
            check("R3 R5 R6 page address", int'(mem_page), m_page);
        end
        if (exp_we) check("R4 write data", int'(mem_wdata), int'(in_byte));
        check("R7 rd_valid", int'(rd_valid), int'(m_rdv));
        check("R8 rd_data", int'(rd_data), m_rdd);
        check("R9 R10 disp_on", int'(disp_on), int'(m_on));
        check("R9 R10 sleep_on", int'(sleep_on), int'(m_sleep));
        check("R9 R10 inverse_on", int'(inverse_on), int'(m_inv));
        check("R11 locked", int'(locked), int'(m_lock));
        check("R11 cfg_bias", int'(cfg_bias), m_bias);
        check("R12 cfg_contrast", int'(cfg_contrast), m_con);
        check("R12 cfg_gain", int'(cfg_gain), m_gain);
        check("R12 cfg_power", int'(cfg_power), m_pow);
    endtask

    task automatic cycle(input bit v, input bit dc, input logic [7:0] b, input bit rq);
        @(negedge clk);
        in_valid = v; in_dc = dc; in_byte = b; rd_req = rq;
        #2;
        compare();
        @(posedge clk);
        #1;
        model_step();
    endtask

    task automatic cmd(input logic [7:0] b); cycle(1'b1, 1'b0, b, 1'b0); endtask
    task automatic dat(input logic [7:0] b); cycle(1'b1, 1'b1, b, 1'b0); endtask
    task automatic rdq(); cycle(1'b0, 1'b0, 8'h00, 1'b1); endtask
    task automatic idle(); cycle(1'b0, 1'b0, 8'h00, 1'b0); endtask

    initial begin
        for (int i = 0; i < NCELL; i++) begin ram[i] = 8'h00; mram[i] = 0; end
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 disp_on reset", int'(disp_on), 0);
        check("R1 locked reset", int'(locked), 0);
        check("R1 strobes reset", int'(mem_we | mem_re | rd_valid), 0);
        check("R1 config reset", int'(cfg_contrast) + int'(cfg_bias) + int'(cfg_power), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(); idle();
        // R9 single-byte opcodes
        cmd(8'hAF); cmd(8'hA7); cmd(8'h95); cmd(8'h94); cmd(8'hA6);
        // R2 R3 R4 R5 windowed write, column-first with wrap
        cmd(8'h15); dat(8'd2); dat(8'd4);
        cmd(8'h75); dat(8'd5); dat(8'd6);
        cmd(8'h5C);
        for (int i = 0; i < 7; i++) dat(8'h10 + 8'(i));
        // R7 R8 read-back with dummy byte and paired advance
        cmd(8'h5D);
        for (int i = 0; i < 8; i++) rdq();
        dat(8'h99);                          // R10 data byte in read mode has no effect
        // R6 page-first order
        cmd(8'hBC); dat(8'h04);
        cmd(8'h5C);
        for (int i = 0; i < 6; i++) dat(8'h20 + 8'(i));
        // R6 both dimensions reversed, column-first
        cmd(8'hBC); dat(8'h03);
        cmd(8'h5C);
        for (int i = 0; i < 6; i++) dat(8'h30 + 8'(i));
        cmd(8'h5D);
        for (int i = 0; i < 6; i++) rdq();
        // R2 R3 saturation and top-page wrap
        cmd(8'h15); dat(8'd40); dat(8'd50);
        cmd(8'h75); dat(8'd128); dat(8'd200);
        cmd(8'hBC); dat(8'h00);
        cmd(8'h5C); dat(8'hA1); dat(8'hA2); dat(8'hA3);
        cmd(8'h5D);
        for (int i = 0; i < 4; i++) rdq();
        // R10 abandoned parameters, stray data byte
        cmd(8'h15); dat(8'd7); cmd(8'hAE); dat(8'h09);
        cmd(8'h5C); dat(8'h41); dat(8'h42);
        // R12 captured configuration, unknown opcode
        cmd(8'h81); dat(8'h2A); dat(8'h05);
        cmd(8'h20); dat(8'h0B); cmd(8'h00);
        // R11 lock and unlock
        cmd(8'hFB); dat(8'h13);
        cmd(8'hAF); cmd(8'h5C); dat(8'h55);
        cmd(8'h5D); rdq();
        cmd(8'h81); dat(8'h3F);
        cmd(8'hFB); dat(8'h05);
        cmd(8'hAF);
        idle(); idle(); idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule